// File: doc/BRIEF.md
# Programmable One-Shot Timeout Timer

This block counts down a programmable number of device-clock ticks once, then signals that the time has run out. Software loads a single 32-bit word. The top bit of that word starts the count, and the low 27 bits set its length in ticks. On the 60 MHz device clock, the longest count is a little over two seconds. When the count runs out, the block does two things in the same cycle: it clears its stored word and sends a one-cycle pulse to the interrupt aggregator. The aggregator latches that pulse as its sticky timeout source bit.

The stored word is also the readback state. A read returns the last word written, with all 32 bits unchanged, until the count expires; after that it reads zero. Writing a word with the top bit clear stops a count in progress without a pulse. Writing a new armed word while a count is running discards the old count and starts again from the new value. The reset input asserts asynchronously and is released on the clock through a two-stage synchronizer.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, the readback word is zero and the timeout pulse is low.
- R2: A write stores the full 32-bit word, and it reads back one cycle after the write edge.
- R3: An armed write (bit 31 set) with count N in bits [26:0] raises the timeout pulse in the cycle that follows the (N+1)-th clock edge after the write edge.
- R4: Each expiry gives exactly one high cycle of the pulse, and no further pulse comes without a new armed write.
- R5: In the cycle the pulse is high, the readback word is already zero.
- R6: A write with bit 31 clear cancels a running count, so no pulse follows it.
- R7: An armed write during a running count restarts the count from the new value. This also holds for a write in the very cycle the old count would expire: only the new expiry produces a pulse.
- R8: An armed write with count zero gives the pulse right after the next clock edge.
- R9: Bits [30:27] of the written word are kept for readback but do not change the count length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device tick clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Write strobe for the timer word |
| wr_data | input | 32 | Word written: bit 31 arms, bits [26:0] hold the count |
| rd_data | output | 32 | Stored word; zero after expiry |
| timeout_pulse | output | 1 | One-cycle expiry pulse to the interrupt aggregator |

## Verification
The bench writes counts of zero, five, three and one thousand. The zero count separates an off-by-one in the expiry edge from a correct one. The long count catches a counter that wraps or decrements more than once per edge. A plain unarmed write, a cancel partway through a count, and a rearm with a shorter value show that the count is driven by the latest write and not the first. A rearm placed in the exact expiry cycle checks that the write wins over the old expiry. A word with bits [30:27] set shows that the count field stops at bit 26, while readback still returns the whole word.

// File: rtl/otm_pkg.sv
package otm_pkg;
  localparam int OTM_WORD_W  = 32;
  localparam int OTM_ARM_BIT = 31;
  localparam int OTM_CNT_W   = 27;

  typedef struct packed {
    logic                 load;
    logic                 arm;
    logic [OTM_CNT_W-1:0] count;
  } otm_cmd_t;
endpackage

// File: rtl/otm_rst_sync.sv
module otm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/otm_decode.sv
module otm_decode
  import otm_pkg::*;
#(
  parameter int WORD_W  = OTM_WORD_W,
  parameter int ARM_BIT = OTM_ARM_BIT,
  parameter int CNT_W   = OTM_CNT_W
) (
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              load,
  output logic              arm,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    load  = wr_en;
    arm   = wr_data[ARM_BIT];
    count = wr_data[CNT_W-1:0];
  end
endmodule

// File: rtl/otm_counter.sv
module otm_counter #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             arm,
  input  logic [CNT_W-1:0] count,
  output logic             fire,
  output logic             pulse
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fire_d;

  // next-state: a write always wins over an expiry in the same cycle
  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (load) begin
      run_d = arm;
      cnt_d = count;
    end else if (run_q && (cnt_q == '0)) begin
      run_d  = 1'b0;
      fire_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load | run_q;
  assign fire   = fire_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire_d;
  end
endmodule

// File: rtl/otm_shadow.sv
module otm_shadow #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fire,
  output logic [WORD_W-1:0] value
);
  logic [WORD_W-1:0] val_d;
  logic              val_en;

  always_comb begin
    val_en = load | fire;
    val_d  = load ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (val_en) value <= val_d;
  end
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer
  import otm_pkg::*;
#(
  parameter int WORD_W  = OTM_WORD_W,
  parameter int ARM_BIT = OTM_ARM_BIT,
  parameter int CNT_W   = OTM_CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              timeout_pulse
);
  logic             rst_sync_n;
  logic             load, arm, fire;
  logic [CNT_W-1:0] count;

  otm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  otm_decode #(.WORD_W(WORD_W), .ARM_BIT(ARM_BIT), .CNT_W(CNT_W)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .load(load), .arm(arm), .count(count)
  );

  otm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .arm(arm), .count(count),
    .fire(fire), .pulse(timeout_pulse)
  );

  otm_shadow #(.WORD_W(WORD_W)) u_val (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .wr_data(wr_data),
    .fire(fire), .value(rd_data)
  );
endmodule

// File: rtl/otm_checker.sv
module otm_checker #(
  parameter int WORD_W  = 32,
  parameter int ARM_BIT = 31,
  parameter int CNT_W   = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              timeout_pulse
);
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_cleared_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (rd_data == '0));

  assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[ARM_BIT]) |=> !timeout_pulse);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[ARM_BIT] && (wr_data[CNT_W-1:0] == '0)) ##1 !wr_en
      |=> timeout_pulse);
endmodule

bind otg_timeout_timer otm_checker #(
  .WORD_W(WORD_W), .ARM_BIT(ARM_BIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .timeout_pulse(timeout_pulse)
);

// File: tb/tb_otg_timeout_timer.sv
`timescale 1ns/1ps
module tb_otg_timeout_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timeout_pulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pulses = 0;
  int exp_q[$];

  otg_timeout_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .timeout_pulse(timeout_pulse)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected expiry cycle and compares it with the observed pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (timeout_pulse) begin
        pulses++;
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected pulse", cyc, 0);
        else begin
          check(cyc == exp_q[0], "R3 pulse cycle", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end
        check(rd_data == 0, "R5 readback at pulse", rd_data, 0);
      end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        check(1'b0, "R3 missed pulse", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // driver: one write, expected items pushed into the queue
  task automatic wr(input logic [31:0] d, input string req);
    @(negedge clk); #1;
    wr_en = 1'b1;
    wr_data = d;
    exp_q.delete();
    if (d[31]) exp_q.push_back(cyc + int'(d[26:0]) + 2);
    @(negedge clk); #1;
    wr_en = 1'b0;
    check(rd_data == d, req, rd_data, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    idle(3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    idle(3);
    check(rd_data == 0, "R1 reset readback", rd_data, 0);
    check(timeout_pulse == 0, "R1 reset pulse", timeout_pulse, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(5);

    // R2: unarmed write just stores the word
    p0 = pulses;
    wr(32'h1234_5678, "R2 readback of unarmed word");
    idle(20);
    check(pulses == p0, "R2 no pulse without arm", pulses - p0, 0);

    // R3: short count
    p0 = pulses;
    wr(32'h8000_0005, "R2 readback of armed word");
    drain();
    check(pulses == p0 + 1, "R3 one pulse for count 5", pulses - p0, 1);
    check(rd_data == 0, "R5 readback zero after expiry", rd_data, 0);

    // R8: zero count
    p0 = pulses;
    wr(32'h8000_0000, "R8 readback");
    drain();
    check(pulses == p0 + 1, "R8 pulse for zero count", pulses - p0, 1);

    // R6: cancel partway through
    p0 = pulses;
    wr(32'h8000_0014, "R6 arm");
    idle(5);
    wr(32'h0000_0007, "R6 cancel word readback");
    idle(40);
    check(pulses == p0, "R6 no pulse after cancel", pulses - p0, 0);
    check(rd_data == 32'h7, "R6 word kept after cancel", rd_data, 32'h7);

    // R7: rearm with shorter count mid-run
    p0 = pulses;
    wr(32'h8000_001e, "R7 first arm");
    idle(10);
    wr(32'h8000_0004, "R7 rearm");
    drain();
    idle(40);
    check(pulses == p0 + 1, "R7 single pulse after rearm", pulses - p0, 1);

    // R7: rearm in the exact expiry cycle of the old count (3 -> expiry edge 4 after write)
    p0 = pulses;
    wr(32'h8000_0003, "R7 arm before edge race");
    idle(2);
    wr(32'h8000_0006, "R7 rearm on expiry edge");
    drain();
    check(pulses == p0 + 1, "R7 old expiry suppressed", pulses - p0, 1);

    // R9: bits 30:27 do not extend the count
    p0 = pulses;
    wr(32'hf800_0003, "R9 full word readback");
    drain();
    check(pulses == p0 + 1, "R9 count taken from bits 26:0", pulses - p0, 1);

    // R3 / R4: long count, then silence
    p0 = pulses;
    wr(32'h8000_03e8, "R3 long count arm");
    drain();
    idle(50);
    check(pulses == p0 + 1, "R4 exactly one pulse per expiry", pulses - p0, 1);
    check(timeout_pulse == 0, "R4 pulse low afterwards", timeout_pulse, 0);

    finish_run();
  end
endmodule